// File: doc/BRIEF.md
# Control Register Bus Master

This block is the initiator side of a simple control-register bus. A host hands it single commands, each a read or a write of one 32-bit register chosen by a 10-bit address. The master places the address on the bus, and for writes the data as well. One clock later it raises a read or write request line. It keeps that request up until the addressed slave acknowledges or a programmable timeout runs out. It then reports the result to the host: the captured read data, or a timeout flag in place of the data.

Commands enter through a valid/ready handshake. `cmd_ready` is high only while the master is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low the host must hold its command, and nothing it presents is used. Results leave as a one-cycle `rsp_valid` pulse, and the host cannot stall it. A request can never be cancelled once it is raised. After an acknowledge or timeout, the request stays high for one more cycle and is then dropped.

Top module: `cfg_bus_master`

## Requirements
- R1: While `rst_n` is low, both request outputs and `rsp_valid` are low and `cmd_ready` is high.
- R2: `cmd_ready` is high only when no command is in progress. A command presented while `cmd_ready` is low is not taken and does not change `bus_addr`.
- R3: The address (and, for writes, the data) from an accepted command appears on `bus_addr`/`bus_wdata` in the cycle after acceptance. The request rises one cycle after that.
- R4: `bus_addr` and `bus_wdata` do not change while a request is high.
- R5: `cmd_write`=1 produces `bus_wr_req` and `cmd_write`=0 produces `bus_rd_req`. The two are never high together.
- R6: If `bus_ack` is first seen high in request cycle C, the request is still high in cycle C+1 and low from cycle C+2.
- R7: For a read, `bus_rdata` is sampled in cycle C and returned on `rsp_rdata` with `rsp_timeout`=0. Later changes to `bus_rdata` do not affect it.
- R8: With limit L on `tmo_limit` (0 counts as 1), a request with no acknowledge stays high for L cycles plus one tail cycle. It is never withdrawn earlier, and it ends with `rsp_timeout`=1.
- R9: An acknowledge in the L-th request cycle, the same cycle in which the timeout expires, completes the command normally with data and `rsp_timeout`=0.
- R10: Each command yields exactly one single-cycle `rsp_valid` pulse. The pulse comes in the first cycle the request is low again, and `rsp_write` echoes the command type.
- R11: `bus_ack` while no request is pending, or in the tail cycle after an acknowledge, is ignored. It raises no response and changes no returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_limit | input | 8 | Timeout limit in request cycles (0 treated as 1) |
| cmd_valid | input | 1 | Host command valid |
| cmd_ready | output | 1 | Master idle, command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 10 | Register address |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_write | output | 1 | Type of the completed command |
| rsp_timeout | output | 1 | Command ended by timeout |
| rsp_rdata | output | 32 | Read data captured at acknowledge |
| bus_addr | output | 10 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_rd_req | output | 1 | Read request strobe |
| bus_wr_req | output | 1 | Write request strobe |
| bus_ack | input | 1 | Slave acknowledge |
| bus_rdata | input | 32 | Slave read data |

## Verification
The acknowledge and the timeout expiry can land in the same cycle. This happens when the slave answers in exactly the last allowed request cycle. The bench provokes it by setting the limit to L and acknowledging in cycle L, including with L of 1 and of 0. It judges the outcome by requiring a normal completion, meaning the acknowledge-cycle data and a clear timeout flag. It also checks that the drop timing is the same as for an earlier acknowledge. Runs with an acknowledge one cycle too late must instead report a timeout.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_REQ   = 2'd2,
    ST_TAIL  = 2'd3
  } cfgm_state_t;
endpackage

// File: rtl/cfgm_timer.sv
module cfgm_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt;
  logic [TW:0]   eff;
  logic [TW:0]   nxt;

  always_comb begin
    eff    = (limit == '0) ? (TW+1)'(1) : {1'b0, limit};
    nxt    = {1'b0, cnt} + (TW+1)'(1);
    expire = run && (nxt >= eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (!expire) cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/cfgm_fsm.sv
module cfgm_fsm
  import cfgm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        bus_ack,
  input  logic        expire,
  output cfgm_state_t state,
  output logic        accept,
  output logic        hit,
  output logic        miss,
  output logic        finish
);
  cfgm_state_t nxt;

  always_comb begin
    accept = (state == ST_IDLE) && cmd_valid;
    hit    = (state == ST_REQ) && bus_ack;
    miss   = (state == ST_REQ) && !bus_ack && expire;
    finish = (state == ST_TAIL);
    unique case (state)
      ST_IDLE:  nxt = accept ? ST_SETUP : ST_IDLE;
      ST_SETUP: nxt = ST_REQ;
      ST_REQ:   nxt = (hit || miss) ? ST_TAIL : ST_REQ;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/cfgm_datapath.sv
module cfgm_datapath #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          hit,
  input  logic          miss,
  input  logic          finish,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          is_write,
  output logic          rsp_valid,
  output logic          rsp_timeout,
  output logic [DW-1:0] rsp_rdata
);
  // command side: loaded once per command, held until the next accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr  <= '0;
      bus_wdata <= '0;
      is_write  <= 1'b0;
    end else if (accept) begin
      bus_addr  <= cmd_addr;
      bus_wdata <= cmd_wdata;
      is_write  <= cmd_write;
    end
  end

  // result side: data frozen at the acknowledge cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_timeout <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid <= finish;
      if (hit) begin
        rsp_rdata   <= bus_rdata;
        rsp_timeout <= 1'b0;
      end else if (miss) begin
        rsp_rdata   <= '0;
        rsp_timeout <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_bus_master.sv
module cfg_bus_master
  import cfgm_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tmo_limit,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic          rsp_write,
  output logic          rsp_timeout,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_rd_req,
  output logic          bus_wr_req,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);
  cfgm_state_t state;
  logic accept, hit, miss, finish, expire, is_write, req_on;

  cfgm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .bus_ack(bus_ack),
    .expire(expire), .state(state), .accept(accept), .hit(hit),
    .miss(miss), .finish(finish)
  );

  cfgm_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_REQ),
    .limit(tmo_limit), .expire(expire)
  );

  cfgm_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .hit(hit), .miss(miss),
    .finish(finish), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .bus_rdata(bus_rdata), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .is_write(is_write), .rsp_valid(rsp_valid),
    .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata)
  );

  always_comb begin
    req_on     = (state == ST_REQ) || (state == ST_TAIL);
    bus_rd_req = req_on && !is_write;
    bus_wr_req = req_on && is_write;
    cmd_ready  = (state == ST_IDLE);
    rsp_write  = is_write;
  end
endmodule

// File: rtl/cfg_bus_master_chk.sv
module cfg_bus_master_chk #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_rd_req,
  input logic          bus_wr_req
);
  logic req;
  assign req = bus_rd_req || bus_wr_req;

  assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !cmd_ready);

  assert_rise_after_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $stable(bus_addr) && $stable(bus_wdata));

  assert_hold_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && $past(req)) |-> $stable(bus_addr) && $stable(bus_wdata));

  assert_excl_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd_req, bus_wr_req}));

  assert_done_on_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> rsp_valid);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !$past(req)) |-> !rsp_valid);
endmodule

bind cfg_bus_master cfg_bus_master_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rd_req(bus_rd_req), .bus_wr_req(bus_wr_req)
);

// File: tb/cfg_bus_master_test.sv
`timescale 1ns/1ps
module cfg_bus_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tmo_limit = 8'd4;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [9:0]  cmd_addr = '0;
  logic [31:0] cmd_wdata = '0, bus_rdata = '0;
  logic        bus_ack = 1'b0;
  logic        cmd_ready, rsp_valid, rsp_write, rsp_timeout, bus_rd_req, bus_wr_req;
  logic [31:0] rsp_rdata, bus_wdata;
  logic [9:0]  bus_addr;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  cfg_bus_master uut (
    .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_write(rsp_write),
    .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rd_req(bus_rd_req), .bus_wr_req(bus_wr_req),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!bus_rd_req && !bus_wr_req, "R1 req low in reset", {bus_rd_req, bus_wr_req}, 0);
    chk(cmd_ready && !rsp_valid, "R1 ready/rsp in reset", {cmd_ready, rsp_valid}, 2);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // ack_at: request cycle index of the acknowledge (0 = none)
  task automatic run_cmd(input bit wr, input logic [9:0] a, input logic [31:0] d,
                         input logic [7:0] lim, input int ack_at, input logic [31:0] rd,
                         input bit junk, input bit tail_ack, input string tag);
    int eff;
    bit acked;
    eff = (lim == 0) ? 1 : int'(lim);
    acked = 1'b0;
    tmo_limit = lim;
    chk(cmd_ready, {tag, " R2 ready when idle"}, cmd_ready, 1);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    // setup cycle
    if (junk) begin cmd_addr = ~a; cmd_wdata = ~d; cmd_write = ~wr; end
    else cmd_valid = 1'b0;
    chk(!cmd_ready, {tag, " R2 busy"}, cmd_ready, 0);
    chk(bus_addr == a, {tag, " R3 addr driven"}, 32'(bus_addr), 32'(a));
    if (wr) chk(bus_wdata == d, {tag, " R3 wdata driven"}, bus_wdata, d);
    chk(!bus_rd_req && !bus_wr_req, {tag, " R3 req not yet"}, {bus_rd_req, bus_wr_req}, 0);
    @(negedge clk);
    for (int k = 1; k <= eff; k++) begin
      if (!acked) begin
        chk(bus_wr_req == wr && bus_rd_req == !wr, {tag, " R5/R8 req held"},
            {bus_rd_req, bus_wr_req}, {wr ? 2'b01 : 2'b10});
        if (k == ack_at) begin bus_ack = 1'b1; bus_rdata = rd; acked = 1'b1; end
        @(negedge clk);
        bus_ack = 1'b0; bus_rdata = 32'hBAD0_0000 | k;
      end
    end
    // tail cycle
    cmd_valid = 1'b0;
    if (tail_ack) begin bus_ack = 1'b1; bus_rdata = 32'hFFFF_0001; end
    chk(bus_wr_req == wr && bus_rd_req == !wr, {tag, " R6 req in tail"},
        {bus_rd_req, bus_wr_req}, {wr ? 2'b01 : 2'b10});
    chk(!rsp_valid, {tag, " R10 no rsp yet"}, rsp_valid, 0);
    chk(bus_addr == a, {tag, " R4 addr held"}, 32'(bus_addr), 32'(a));
    @(negedge clk);
    bus_ack = 1'b0;
    chk(!bus_rd_req && !bus_wr_req, {tag, " R6 req dropped"}, {bus_rd_req, bus_wr_req}, 0);
    chk(rsp_valid && rsp_write == wr, {tag, " R10 rsp pulse"}, {rsp_valid, rsp_write}, {1'b1, wr});
    chk(rsp_timeout == !acked, {tag, " R8/R9 timeout flag"}, rsp_timeout, !acked);
    if (acked && !wr) chk(rsp_rdata == rd, {tag, " R7 read data"}, rsp_rdata, rd);
    @(negedge clk);
    chk(!rsp_valid, {tag, " R10 single pulse"}, rsp_valid, 0);
    if (acked && !wr) chk(rsp_rdata == rd, {tag, " R7/R11 data kept"}, rsp_rdata, rd);
  endtask

  task automatic t_stray_ack();
    bus_ack = 1'b1; bus_rdata = 32'h1234_5678;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!rsp_valid && !bus_rd_req && !bus_wr_req && cmd_ready, "R11 idle ack ignored",
          {rsp_valid, bus_rd_req, bus_wr_req, cmd_ready}, 1);
    end
    bus_ack = 1'b0;
  endtask

  initial begin
    t_reset();
    run_cmd(1'b0, 10'h155, 32'h0, 8'd6, 2, 32'hCAFE_F00D, 1'b0, 1'b0, "read ack2");
    run_cmd(1'b1, 10'h2AA, 32'hA5A5_1234, 8'd6, 1, 32'h0, 1'b0, 1'b0, "write ack1");
    run_cmd(1'b0, 10'h001, 32'h0, 8'd3, 0, 32'h0, 1'b0, 1'b0, "read timeout");
    run_cmd(1'b1, 10'h3FF, 32'h0BAD_BEEF, 8'd2, 0, 32'h0, 1'b0, 1'b0, "write timeout");
    run_cmd(1'b0, 10'h0F0, 32'h0, 8'd4, 4, 32'h7777_0004, 1'b0, 1'b0, "R9 ack at expiry");
    run_cmd(1'b0, 10'h0F1, 32'h0, 8'd1, 1, 32'h1111_0001, 1'b0, 1'b0, "R9 limit1");
    run_cmd(1'b0, 10'h0F2, 32'h0, 8'd0, 1, 32'h2222_0000, 1'b0, 1'b0, "R9 limit0");
    run_cmd(1'b0, 10'h0F3, 32'h0, 8'd3, 4, 32'h3333_0000, 1'b0, 1'b0, "R8 late ack");
    run_cmd(1'b0, 10'h123, 32'h0, 8'd8, 3, 32'h4444_5555, 1'b1, 1'b1, "R2/R11 junk+tail ack");
    t_stray_ack();
    run_cmd(1'b1, 10'h200, 32'hDEAD_0001, 8'd10, 7, 32'h0, 1'b0, 1'b0, "write ack7");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule